// File: doc/BRIEF.md
# Clock Output Stop and Power-Down Gating

This block sits between the clock dividers of a motherboard clock generator and its output pads. It receives the free-running divided clocks (three CPU clocks, seven stoppable PCI clocks, three normally free-running PCI clocks, six 66 MHz clocks and the two 48 MHz clocks). It decides which of them reach the pins from three active-low control pins: power-down, CPU-stop and PCI-stop.

Configuration bits from a register file add three things:
- an enable for every output;
- a free-run override for each CPU pair;
- a "stop with PCI-stop" opt-in for each free-running PCI clock.

For each CPU pair the block also drives a flag. The flag tells the differential driver to float the complement output while the true output is parked.

Every gating decision is synchronised into the domain of the clock it gates. Starting and stopping happen only while that clock is low, so an output shows only whole clock pulses.

Top module: `clkout_stop_gate`

## Requirements
- R1: While reset is held, every gated output is low and every CPU complement-float flag is 1.
- R2: With the power-down pin low, all PCI, free-running PCI, 66 MHz, USB and DOT outputs stay low whatever the stop pins are. The oscillator-enable output equals the power-down pin level.
- R3: A stopped CPU output is parked at a static low level with its complement-float flag at 1. A running CPU output has its flag at 0. Power-down stops every CPU output.
- R4: With CPU-stop low and power-down high, CPU output i stops when its free-run bit `cpu_free[i]` is 0 and keeps running when it is 1.
- R5: With PCI-stop low, PCI outputs 0 to 6 stop.
- R6: With PCI-stop low and power-down high, free-running PCI output i keeps running when `pcif_stoppable[i]` is 0 and stops when it is 1.
- R7: The CPU-stop and PCI-stop pins have no effect on the 66 MHz, USB and DOT outputs.
- R8: An output whose enable bit is 0 stays low. For a CPU output, its complement-float flag is then 1. Enable bit value 1 means enabled.
- R9: Every high pulse on a gated output lasts a full high phase of its source clock; no shortened pulse appears when gating changes.
- R10: A change on a control pin takes effect on an output within three periods of that output's source clock. The pin passes through two flip-flops clocked by that source clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_cpu | input | N_CPU | Running CPU clocks |
| clk_pci | input | N_PCI | Running stoppable PCI clocks |
| clk_pcif | input | N_PCIF | Running free-running PCI clocks |
| clk_66 | input | N_66 | Running 66 MHz clocks |
| clk_usb | input | 1 | Running 48 MHz USB clock |
| clk_dot | input | 1 | Running 48 MHz DOT clock |
| pwrdn_n | input | 1 | Power-down, active low, asynchronous |
| cpu_stop_n | input | 1 | CPU stop, active low, asynchronous |
| pci_stop_n | input | 1 | PCI stop, active low, asynchronous |
| cpu_en | input | N_CPU | Per-CPU-pair enable |
| cpu_free | input | N_CPU | Per-CPU-pair free-run override against CPU-stop |
| pci_en | input | N_PCI | Per-PCI-output enable |
| pcif_en | input | N_PCIF | Per free-running PCI output enable |
| pcif_stoppable | input | N_PCIF | 1 lets PCI-stop stop that free-running PCI output |
| m66_en | input | N_66 | Per 66 MHz output enable |
| usb_en | input | 1 | USB output enable |
| dot_en | input | 1 | DOT output enable |
| cpu_out | output | N_CPU | Gated CPU true clocks |
| cpu_c_float | output | N_CPU | 1 = float the complement of that CPU pair |
| pci_out | output | N_PCI | Gated PCI clocks |
| pcif_out | output | N_PCIF | Gated free-running PCI clocks |
| m66_out | output | N_66 | Gated 66 MHz clocks |
| usb_out | output | 1 | Gated USB clock |
| dot_out | output | 1 | Gated DOT clock |
| osc_en | output | 1 | Oscillator and VCO enable |

## Verification
The bench builds the block with its default counts: three CPU pairs, seven PCI, three free-running PCI and six 66 MHz outputs. This puts every output class and every override in reach. It runs all eight levels of the three control pins under three register settings: reset defaults, all overrides set, and a mixed pattern with some outputs disabled. Every truth-table row is therefore seen with and without free-run overrides. Pins change at times unrelated to any source clock, so the high-pulse width monitor sees gating edges at arbitrary phases in four clock domains.

// File: rtl/clkout_stop_gate.sv
`timescale 1ns/1ps
module clkout_stop_gate #(
  parameter int N_CPU  = 3,
  parameter int N_PCI  = 7,
  parameter int N_PCIF = 3,
  parameter int N_66   = 6
) (
  input  logic              rst_n,
  input  logic [N_CPU-1:0]  clk_cpu,
  input  logic [N_PCI-1:0]  clk_pci,
  input  logic [N_PCIF-1:0] clk_pcif,
  input  logic [N_66-1:0]   clk_66,
  input  logic              clk_usb,
  input  logic              clk_dot,
  input  logic              pwrdn_n,
  input  logic              cpu_stop_n,
  input  logic              pci_stop_n,
  input  logic [N_CPU-1:0]  cpu_en,
  input  logic [N_CPU-1:0]  cpu_free,
  input  logic [N_PCI-1:0]  pci_en,
  input  logic [N_PCIF-1:0] pcif_en,
  input  logic [N_PCIF-1:0] pcif_stoppable,
  input  logic [N_66-1:0]   m66_en,
  input  logic              usb_en,
  input  logic              dot_en,
  output logic [N_CPU-1:0]  cpu_out,
  output logic [N_CPU-1:0]  cpu_c_float,
  output logic [N_PCI-1:0]  pci_out,
  output logic [N_PCIF-1:0] pcif_out,
  output logic [N_66-1:0]   m66_out,
  output logic              usb_out,
  output logic              dot_out,
  output logic              osc_en
);
  localparam int N_ALL = N_CPU + N_PCI + N_PCIF + N_66 + 2;

  logic [N_CPU-1:0]  run_cpu;
  logic [N_PCI-1:0]  run_pci;
  logic [N_PCIF-1:0] run_pcif;
  logic [N_66-1:0]   run_66;
  logic [N_ALL-1:0]  src, run_req, gate, gated;

  assign run_cpu  = cpu_en & {N_CPU{pwrdn_n}} & (cpu_free | {N_CPU{cpu_stop_n}});
  assign run_pci  = pci_en & {N_PCI{pwrdn_n & pci_stop_n}};
  assign run_pcif = pcif_en & {N_PCIF{pwrdn_n}} & (~pcif_stoppable | {N_PCIF{pci_stop_n}});
  assign run_66   = m66_en & {N_66{pwrdn_n}};

  assign src     = {clk_dot, clk_usb, clk_66, clk_pcif, clk_pci, clk_cpu};
  assign run_req = {dot_en & pwrdn_n, usb_en & pwrdn_n, run_66, run_pcif, run_pci, run_cpu};

  for (genvar i = 0; i < N_ALL; i++) begin : g_gate
    logic sync1, sync2, gate_q;

    always_ff @(posedge src[i] or negedge rst_n)
      if (!rst_n) begin
        sync1 <= 1'b0;
        sync2 <= 1'b0;
      end else begin
        sync1 <= run_req[i];
        sync2 <= sync1;
      end

    always_ff @(negedge src[i] or negedge rst_n)
      if (!rst_n) gate_q <= 1'b0;
      else        gate_q <= sync2;

    assign gate[i] = gate_q;
  end

  assign gated = src & gate;

  assign cpu_out     = gated[N_CPU-1:0];
  assign cpu_c_float = ~gate[N_CPU-1:0];
  assign pci_out     = gated[N_CPU +: N_PCI];
  assign pcif_out    = gated[N_CPU+N_PCI +: N_PCIF];
  assign m66_out     = gated[N_CPU+N_PCI+N_PCIF +: N_66];
  assign usb_out     = gated[N_ALL-2];
  assign dot_out     = gated[N_ALL-1];
  assign osc_en      = pwrdn_n;
endmodule

// File: rtl/clkout_stop_gate_chk.sv
`timescale 1ns/1ps
module clkout_stop_gate_chk #(
  parameter int N_CPU  = 3,
  parameter int N_PCI  = 7,
  parameter int N_PCIF = 3,
  parameter int N_66   = 6
) (
  input logic              rst_n,
  input logic [N_CPU-1:0]  clk_cpu,
  input logic [N_PCI-1:0]  clk_pci,
  input logic [N_PCIF-1:0] clk_pcif,
  input logic [N_66-1:0]   clk_66,
  input logic              pwrdn_n,
  input logic              pci_stop_n,
  input logic [N_PCIF-1:0] pcif_en,
  input logic [N_PCIF-1:0] pcif_stoppable,
  input logic [N_66-1:0]   m66_en,
  input logic [N_CPU-1:0]  cpu_out,
  input logic [N_CPU-1:0]  cpu_c_float,
  input logic [N_PCI-1:0]  pci_out,
  input logic [N_PCIF-1:0] pcif_out,
  input logic [N_66-1:0]   m66_out
);
  assert_pwrdn_low_R2: assert property (@(negedge clk_pci[0]) disable iff (!rst_n)
    (!pwrdn_n && !$past(pwrdn_n,1) && !$past(pwrdn_n,2) && !$past(pwrdn_n,3)) |-> !pci_out[0]);

  assert_cpu_park_R3: assert property (@(negedge clk_cpu[0]) disable iff (!rst_n)
    (!pwrdn_n && !$past(pwrdn_n,1) && !$past(pwrdn_n,2) && !$past(pwrdn_n,3))
      |-> (cpu_c_float[0] && !cpu_out[0]));

  assert_pci_stop_R5: assert property (@(negedge clk_pci[0]) disable iff (!rst_n)
    (!pci_stop_n && !$past(pci_stop_n,1) && !$past(pci_stop_n,2) && !$past(pci_stop_n,3))
      |-> !pci_out[0]);

  assert_pcif_free_R6: assert property (@(negedge clk_pcif[0]) disable iff (!rst_n)
    ($past(rst_n,1) && $past(rst_n,2) && $past(rst_n,3) &&
     pwrdn_n && $past(pwrdn_n,1) && $past(pwrdn_n,2) && $past(pwrdn_n,3) &&
     pcif_en[0] && $past(pcif_en[0],3) && !pcif_stoppable[0] && !$past(pcif_stoppable[0],3))
      |-> pcif_out[0]);

  assert_m66_runs_R7: assert property (@(negedge clk_66[0]) disable iff (!rst_n)
    ($past(rst_n,1) && $past(rst_n,2) && $past(rst_n,3) &&
     pwrdn_n && $past(pwrdn_n,1) && $past(pwrdn_n,2) && $past(pwrdn_n,3) &&
     m66_en[0] && $past(m66_en[0],3))
      |-> m66_out[0]);
endmodule

bind clkout_stop_gate clkout_stop_gate_chk #(
  .N_CPU(N_CPU), .N_PCI(N_PCI), .N_PCIF(N_PCIF), .N_66(N_66)
) u_chk (
  .rst_n(rst_n), .clk_cpu(clk_cpu), .clk_pci(clk_pci), .clk_pcif(clk_pcif),
  .clk_66(clk_66), .pwrdn_n(pwrdn_n), .pci_stop_n(pci_stop_n),
  .pcif_en(pcif_en), .pcif_stoppable(pcif_stoppable), .m66_en(m66_en),
  .cpu_out(cpu_out), .cpu_c_float(cpu_c_float), .pci_out(pci_out),
  .pcif_out(pcif_out), .m66_out(m66_out)
);

// File: tb/tb_clkout_stop_gate.sv
`timescale 1ns/1ps
module tb_clkout_stop_gate;
  localparam int NC = 3, NP = 7, NF = 3, N6 = 6;
  localparam int NA = NC + NP + NF + N6 + 2;

  logic clk = 0, clk_p = 0, clk_m = 0, clk_u = 0, rst_n = 0;
  always #2.5   clk   = ~clk;
  always #15    clk_p = ~clk_p;
  always #7.5   clk_m = ~clk_m;
  always #10.417 clk_u = ~clk_u;

  logic pwrdn_n = 1, cpu_stop_n = 1, pci_stop_n = 1;
  logic [NC-1:0] cpu_en = '1, cpu_free = '0;
  logic [NP-1:0] pci_en = '1;
  logic [NF-1:0] pcif_en = '1, pcif_stoppable = '0;
  logic [N6-1:0] m66_en = '1;
  logic usb_en = 1, dot_en = 1;

  logic [NC-1:0] cpu_out, cpu_c_float;
  logic [NP-1:0] pci_out;
  logic [NF-1:0] pcif_out;
  logic [N6-1:0] m66_out;
  logic usb_out, dot_out, osc_en;

  clkout_stop_gate #(.N_CPU(NC), .N_PCI(NP), .N_PCIF(NF), .N_66(N6)) dut (
    .rst_n(rst_n), .clk_cpu({NC{clk}}), .clk_pci({NP{clk_p}}), .clk_pcif({NF{clk_p}}),
    .clk_66({N6{clk_m}}), .clk_usb(clk_u), .clk_dot(clk_u),
    .pwrdn_n(pwrdn_n), .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n),
    .cpu_en(cpu_en), .cpu_free(cpu_free), .pci_en(pci_en), .pcif_en(pcif_en),
    .pcif_stoppable(pcif_stoppable), .m66_en(m66_en), .usb_en(usb_en), .dot_en(dot_en),
    .cpu_out(cpu_out), .cpu_c_float(cpu_c_float), .pci_out(pci_out), .pcif_out(pcif_out),
    .m66_out(m66_out), .usb_out(usb_out), .dot_out(dot_out), .osc_en(osc_en));

  wire [NA-1:0] o_all = {dot_out, usb_out, m66_out, pcif_out, pci_out, cpu_out};

  int vectors = 0, fails = 0;
  bit done = 0;
  int rise_cnt[NA];
  int short_cnt[NA];
  real t_up[NA];

  function automatic real half_of(int i);
    if (i < NC) return 2.5;
    if (i < NC + NP + NF) return 15.0;
    if (i < NC + NP + NF + N6) return 7.5;
    return 10.417;
  endfunction

  for (genvar g = 0; g < NA; g++) begin : g_mon
    initial begin rise_cnt[g] = 0; short_cnt[g] = 0; t_up[g] = 0.0; end
    always @(posedge o_all[g]) begin
      rise_cnt[g] = rise_cnt[g] + 1;
      t_up[g] = $realtime;
    end
    always @(negedge o_all[g])
      if ($realtime - t_up[g] < half_of(g) - 0.05) short_cnt[g] = short_cnt[g] + 1;
  end

  function automatic bit exp_run(int i);
    int k;
    if (!pwrdn_n) return 0;                                    // R2, R3
    if (i < NC) return cpu_en[i] && (cpu_stop_n || cpu_free[i]); // R4, R8
    k = i - NC;
    if (k < NP) return pci_en[k] && pci_stop_n;                // R5
    k = k - NP;
    if (k < NF) return pcif_en[k] && (pci_stop_n || !pcif_stoppable[k]); // R6
    k = k - NF;
    if (k < N6) return m66_en[k];                              // R7
    return (k == N6) ? usb_en : dot_en;                        // R7
  endfunction

  function automatic string tag_of(int i);
    if (i < NC) return "R3/R4/R8/R10";
    if (i < NC + NP) return "R2/R5/R8/R10";
    if (i < NC + NP + NF) return "R2/R6/R8/R10";
    return "R2/R7/R8/R10";
  endfunction

  task automatic chk(bit ok, string tag, int idx, int act, int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s out%0d actual=%0d expected=%0d", tag, idx, act, exp);
    end
  endtask

  task automatic scenario();
    int start[NA];
    #200;
    for (int i = 0; i < NA; i++) start[i] = rise_cnt[i];
    #300.3;
    for (int i = 0; i < NA; i++) begin
      int d = rise_cnt[i] - start[i];
      bit e = exp_run(i);
      if (e) chk(d > 0, tag_of(i), i, d, 1);
      else   chk(d == 0 && o_all[i] == 1'b0, tag_of(i), i, d, 0);
    end
    for (int i = 0; i < NC; i++)
      chk(cpu_c_float[i] == !exp_run(i), "R3 float", i, cpu_c_float[i], !exp_run(i));
    chk(osc_en == pwrdn_n, "R2 osc_en", 0, osc_en, pwrdn_n);
  endtask

  initial begin
    int start[NA];
    #3.1;
    for (int i = 0; i < NA; i++) start[i] = rise_cnt[i];
    #300;
    for (int i = 0; i < NA; i++)
      chk(rise_cnt[i] == start[i] && o_all[i] == 1'b0, "R1", i, rise_cnt[i] - start[i], 0);
    chk(cpu_c_float == '1, "R1 float", 0, cpu_c_float, 7);
    rst_n = 1;
    for (int c = 0; c < 3; c++) begin
      if (c == 1) begin
        cpu_free = '1; pcif_stoppable = '1;
      end else if (c == 2) begin
        cpu_en = 3'b101; cpu_free = 3'b011; pci_en = 7'b1010101;
        pcif_en = 3'b110; pcif_stoppable = 3'b101; m66_en = 6'b100110;
        usb_en = 0; dot_en = 1;
      end
      for (int p = 0; p < 8; p++) begin
        #(1.37 * p + 0.61);
        {pwrdn_n, cpu_stop_n, pci_stop_n} = 3'(p);
        scenario();
      end
    end
    for (int i = 0; i < NA; i++) chk(short_cnt[i] == 0, "R9 short pulse", i, short_cnt[i], 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      vectors++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule